// File: doc/BRIEF.md
# Presettable Split Binary Counter

This block is a four-bit binary counter made of two sections, each with its own count input. A one-bit toggle section drives output bit 0 from the first count input. A three-bit counter section drives output bits 3 to 1 from the second count input. All logic runs on a system clock. Each count input is sampled on that clock, and a high-to-low change between two samples counts as one count event.

When the first count input is fed from an outside source and output bit 0 is wired back to the second count input, the two sections form a modulo-16 binary counter. Bit 0 is then the least significant bit and bit 3 the most significant. Because the wired-back bit is sampled on the clock, the upper section advances one clock after bit 0 falls.

An active-low clear overrides every other input. An active-low load makes the outputs follow the data inputs transparently, and counting is suspended while it is low. Releasing the load holds the last captured data, so the block can also serve as a four-bit latch.

Top module: `split_bin_counter`

## Requirements
- R1: While `mclr_n` is low, `q` is 0 whatever `load_n`, `din`, `tick0` and `tick1` do. This takes effect without waiting for a clock edge.
- R2: While `mclr_n` is high and `load_n` is low, `q` equals `din` in the same cycle and follows every change of `din`.
- R3: A count event on `tick0` is `tick0` sampled high on one clock edge and low on the next, with `mclr_n` and `load_n` both high. Each such event inverts `q[0]` after that second edge.
- R4: A count event on `tick1`, defined the same way, adds one modulo 8 to `q[3:1]`. The value 7 is followed by 0.
- R5: When neither count input has a count event and `load_n` stays high, `q` keeps its value.
- R6: When `load_n` rises, `q` holds the value `din` had at the last clock edge while `load_n` was low.
- R7: A falling count input while `load_n` is low is ignored. The count stays at the loaded value after the load is released.
- R8: With `q[0]` fed back to `tick1` and edges applied to `tick0`, `q` steps through 0 to 15 in binary and returns to 0 on the event after 15. Bit 0 is the least significant bit.
- R9: A count input held low, or rising, produces no count event. A count input that is already low when `mclr_n` is released gives no event until it has gone high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; count inputs are sampled on its rising edge |
| mclr_n | input | 1 | Active-low clear, top priority |
| load_n | input | 1 | Active-low transparent load |
| din | input | 4 | Data captured by the load |
| tick0 | input | 1 | Count input of the one-bit section |
| tick1 | input | 1 | Count input of the three-bit section |
| q | output | 4 | Counter outputs, bit 0 from the one-bit section |

## Verification
The hardest case to reach is a count input falling while the load is still held, just before release. That edge must be swallowed and must not show up as a late count. To reach it, the bench lowers both count inputs during a load and then releases the load with the inputs still low. A second hard case is the feedback cascade crossing from 15 back to 0, where the upper section lags bit 0 by a clock. The bench reaches it by looping `q[0]` back to `tick1` and driving `tick0` through more than one full period of sixteen counts.

// File: rtl/split_bin_counter.sv
module split_bin_counter #(
  parameter int HI_W = 3
) (
  input  logic          clk,
  input  logic          mclr_n,
  input  logic          load_n,
  input  logic [HI_W:0] din,
  input  logic          tick0,
  input  logic          tick1,
  output logic [HI_W:0] q
);

  localparam int W = HI_W + 1;

  logic            lo_q;
  logic [HI_W-1:0] hi_q;
  logic            prev0, prev1;
  logic            fall0, fall1;

  assign fall0 = prev0 & ~tick0 & load_n;
  assign fall1 = prev1 & ~tick1 & load_n;

  always_ff @(posedge clk or negedge mclr_n) begin
    if (!mclr_n) begin
      prev0 <= 1'b0;
      prev1 <= 1'b0;
    end else begin
      prev0 <= tick0;
      prev1 <= tick1;
    end
  end

  always_ff @(posedge clk or negedge mclr_n) begin
    if (!mclr_n)      lo_q <= 1'b0;
    else if (!load_n) lo_q <= din[0];
    else if (fall0)   lo_q <= ~lo_q;
  end

  always_ff @(posedge clk or negedge mclr_n) begin
    if (!mclr_n)      hi_q <= '0;
    else if (!load_n) hi_q <= din[HI_W:1];
    else if (fall1)   hi_q <= hi_q + HI_W'(1);
  end

  assign q = !mclr_n ? W'(0) : (!load_n ? din : {hi_q, lo_q});

  p_clear_zero_r1: assert property (@(posedge clk) !mclr_n |-> q == W'(0));

  p_load_follow_r2: assert property (@(posedge clk) disable iff (!mclr_n)
    !load_n |-> q == din);

  p_lo_toggle_r3: assert property (@(posedge clk) disable iff (!mclr_n)
    fall0 |=> (!load_n || q[0] != $past(q[0])));

  p_hi_step_r4: assert property (@(posedge clk) disable iff (!mclr_n)
    fall1 |=> (!load_n || q[HI_W:1] == $past(q[HI_W:1]) + HI_W'(1)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!mclr_n)
    (load_n && !fall0 && !fall1) |=> (!load_n || q == $past(q)));

  p_latch_r6: assert property (@(posedge clk) disable iff (!mclr_n)
    ($rose(load_n) && !fall0 && !fall1) |-> q == $past(din));

endmodule

// File: tb/tb_split_bin_counter.sv
`timescale 1ns/1ps
module tb_split_bin_counter;

  logic       clk = 1'b0;
  logic       mclr_n, load_n, tick0, t1_drv, cascade;
  logic [3:0] din;
  logic [3:0] q;
  logic       tick1;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_en = 0;
  string cur_req = "R1";

  int m_cnt = 0;
  bit m_p0 = 0, m_p1 = 0;

  always #2.5 clk = ~clk;

  assign tick1 = cascade ? q[0] : t1_drv;

  split_bin_counter dut (
    .clk(clk), .mclr_n(mclr_n), .load_n(load_n), .din(din),
    .tick0(tick0), .tick1(tick1), .q(q)
  );

  function automatic int model_q();
    if (!mclr_n) return 0;
    if (!load_n) return int'(din);
    return m_cnt;
  endfunction

  always @(posedge clk) begin
    bit t1, f0, f1;
    int cur;
    cur = model_q();
    t1 = cascade ? cur[0] : t1_drv;
    if (!mclr_n) begin
      m_cnt = 0; m_p0 = 0; m_p1 = 0;
    end else begin
      f0 = m_p0 && !tick0;
      f1 = m_p1 && !t1;
      if (!load_n) m_cnt = int'(din);
      else begin
        if (f0) m_cnt = m_cnt ^ 1;
        if (f1) m_cnt = (m_cnt & 1) | ((((m_cnt >> 1) + 1) % 8) << 1);
      end
      m_p0 = tick0;
      m_p1 = t1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_en && !done) chk(cur_req, int'(q), model_q());

  task automatic cyc(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic pulse0(int n);
    repeat (n) begin tick0 = 1; cyc(2); tick0 = 0; cyc(2); end
  endtask

  task automatic pulse1(int n);
    repeat (n) begin t1_drv = 1; cyc(2); t1_drv = 0; cyc(2); end
  endtask

  initial begin
    mclr_n = 0; load_n = 1; din = 4'h0; tick0 = 0; t1_drv = 0; cascade = 0;
    cyc(1);
    cmp_en = 1;
    cur_req = "R1";
    load_n = 0; din = 4'hA; tick0 = 1; cyc(1); tick0 = 0; cyc(2);
    chk("R1", int'(q), 0);
    load_n = 1;
    cyc(1);
    mclr_n = 1;
    cyc(2);
    chk("R9", int'(q), 0);

    cur_req = "R3";
    pulse0(3);
    chk("R3", int'(q), 1);

    cur_req = "R4";
    pulse1(5);
    chk("R4", int'(q), 11);
    pulse1(3);
    chk("R4", int'(q), 1);

    cur_req = "R5";
    cyc(6);
    chk("R5", int'(q), 1);

    cur_req = "R9";
    tick0 = 1; cyc(1); tick0 = 0; cyc(10);
    chk("R9", int'(q), 0);
    tick0 = 1; cyc(4);
    chk("R9", int'(q), 0);
    tick0 = 0; cyc(2);

    cur_req = "R2";
    load_n = 0;
    for (int i = 0; i < 6; i++) begin
      din = 4'(i * 5 + 3);
      #0.5 chk("R2", int'(q), (i * 5 + 3) % 16);
      cyc(1);
    end

    cur_req = "R6";
    din = 4'h6; cyc(1);
    load_n = 1; din = 4'h9; cyc(3);
    chk("R6", int'(q), 6);

    cur_req = "R7";
    tick0 = 1; t1_drv = 1; cyc(2);
    load_n = 0; din = 4'h4; cyc(2);
    tick0 = 0; t1_drv = 0; cyc(2);
    load_n = 1; cyc(4);
    chk("R7", int'(q), 4);

    cur_req = "R8";
    mclr_n = 0; cyc(1); mclr_n = 1; cyc(1);
    cascade = 1;
    pulse0(15);
    chk("R8", int'(q), 15);
    pulse0(1);
    chk("R8", int'(q), 0);
    pulse0(21);
    chk("R8", int'(q), 5);

    cur_req = "R1";
    @(posedge clk); #1;
    mclr_n = 0;
    #0.5 chk("R1", int'(q), 0);
    cyc(2);
    mclr_n = 1; cascade = 0;
    cyc(2);

    cmp_en = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule